// File: doc/BRIEF.md
# SPI Memory Bridge

The bridge is an SPI target in mode 0 that opens a local 32-bit memory port to an external SPI master. Each transaction starts when chip select falls. The first byte is a command that picks the direction and the access width. A 32-bit address follows, most significant byte first. A write then sends its data at once. A read first lets four dummy bytes pass and then shifts the fetched data out on `miso`.

Three access widths exist: a 2-byte half word, a 4-byte word and an 8-byte burst word. On the wire every word goes most significant byte first, while the memory holds it little-endian. A burst repeats 8-byte words and advances the address by 8 after each word, up to a byte limit. Half-word accesses are allowed only inside a fixed address window. An access outside that window leaves memory untouched, reads back as zero and sets a sticky flag.

`sclk`, `cs_n` and `mosi` are brought into the system clock domain through two-flop synchronizers. All protocol work runs on the system clock, so `sclk` must be several times slower than `clk`.

Top module: `spi_mem_bridge`

## Requirements
- R1: The first byte selects the operation: 0x00 half read, 0x01 half write, 0x02 word read, 0x03 word write, 0x04 burst read, 0x05 burst write. Any other byte value, including 0x80 and above, makes the bridge ignore the rest of the transaction. It then makes no memory access and holds `miso` low.
- R2: The next four bytes form the address, most significant byte first. Address bits below the word size of the command are ignored: 1 bit for half, 2 bits for word, 3 bits for burst.
- R3: A word of W bytes (W = 2, 4 or 8) is sent most significant byte first. The k-th byte of the word (k = 0 first) belongs to address base + W - 1 - k.
- R4: A read returns 0x00 on `miso` during the four bytes after the address. The data starts with the byte that follows them.
- R5: A half access is allowed only when its aligned address lies in [WIN_LO, WIN_HI], both ends included. Outside the window a half write changes no memory and a half read returns zeros. The window does not apply to word or burst accesses.
- R6: `win_err` is 0 after reset. A half access outside the window sets it, and it stays 1 until reset.
- R7: A burst moves consecutive 8-byte words at base, base+8, and so on, up to MAX_BURST bytes. Write bytes beyond the limit are ignored, and read bytes beyond the limit are 0x00.
- R8: A half or word command moves exactly one word. Further write bytes are ignored, and further read bytes are 0x00.
- R9: Memory is written only after all bytes of a word have arrived. A partial word left when `cs_n` rises is dropped.
- R10: Every memory request uses a 4-byte aligned address. Reads and word or burst writes enable all four lanes. A half write enables lanes 1:0 when address bit 1 is 0 and lanes 3:2 when it is 1, so the other half of the word is kept. Read data is taken one clock after the request.
- R11: After reset `miso` is low and no memory request is made. `miso` also returns low after `cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| mem_req | output | 1 | Memory request strobe, one cycle per access |
| mem_we | output | 1 | 1 for a write request, 0 for a read request |
| mem_addr | output | 32 | Byte address of the request, 4-byte aligned |
| mem_be | output | 4 | Byte lane enables of a write |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| win_err | output | 1 | Sticky flag for a half access outside the window |

## Verification
The bench builds the bridge with MAX_BURST set to 32 bytes and keeps the default half-word window. With only four burst words allowed, the bench can sweep every burst length from one word to one word past the limit. Doing so reaches both the last allowed word and the cut-off behaviour for reads and writes. Because the window keeps its real bounds, both inclusive edges and the first addresses outside them are probed directly, together with both halves of a word.

// File: rtl/spi_mem_bridge.sv
`timescale 1ns/1ps
module spi_mem_bridge #(
  parameter logic [31:0] WIN_LO    = 32'h1802_0000,
  parameter logic [31:0] WIN_HI    = 32'h1802_1000,
  parameter int          MAX_BURST = 240
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        win_err
);
  localparam int MAXW = MAX_BURST / 8;
  localparam int WCW  = $clog2(MAXW + 1);

  logic [2:0] sclk_q;
  logic [1:0] cs_q, mosi_q;
  logic [2:0] bcnt;
  logic [6:0] rx;
  logic [3:0] bidx;
  logic [2:0] cmd;
  logic [23:0] addr;
  logic [31:0] nxt;
  logic half_hi, blk, dead, tx_en;
  logic [2:0] wb;
  logic [WCW-1:0] wcnt;
  logic [55:0] wsr;
  logic [63:0] tx, rbuf;
  logic [1:0] seq_left;
  logic seq_we, seq_hi, rd_pend, rd_hi;
  logic [31:0] seq_addr;
  logic [63:0] seq_wd;
  logic [3:0] seq_be;

  wire sel  = ~cs_q[1];
  wire rise = sclk_q[1] & ~sclk_q[2];
  wire [7:0] byte_in = {rx, mosi_q[1]};
  wire [63:0] wfull = {wsr, byte_in};
  wire is_rd = ~cmd[0];
  wire burst = cmd[2];
  wire half  = (cmd[2:1] == 2'b00);
  wire [2:0] wlast = burst ? 3'd7 : (half ? 3'd1 : 3'd3);
  wire [31:0] wstep = burst ? 32'd8 : (half ? 32'd2 : 32'd4);
  wire [31:0] full_addr = {addr, byte_in};
  wire [31:0] aln_addr = full_addr & (burst ? ~32'd7 : (half ? ~32'd1 : ~32'd3));
  wire in_win = (aln_addr >= WIN_LO) && (aln_addr <= WIN_HI);
  wire [63:0] tx_load = burst ? rbuf
                      : half ? {(half_hi ? rbuf[31:16] : rbuf[15:0]), 48'h0}
                      : {rbuf[31:0], 32'h0};

  logic [63:0] wr_wd;
  logic [3:0]  wr_be;
  always_comb begin
    wr_wd = {32'h0, wfull[31:0]};
    wr_be = 4'hF;
    if (burst) wr_wd = wfull;
    else if (half) begin
      wr_wd = nxt[1] ? {32'h0, wfull[15:0], 16'h0} : {48'h0, wfull[15:0]};
      wr_be = nxt[1] ? 4'b1100 : 4'b0011;
    end
  end

  assign miso      = tx_en & tx[63];
  assign mem_req   = (seq_left != 2'd0);
  assign mem_we    = seq_we;
  assign mem_addr  = seq_addr;
  assign mem_be    = seq_be;
  assign mem_wdata = seq_wd[31:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt <= '0; rx <= '0; bidx <= '0; cmd <= '0; addr <= '0; nxt <= '0;
      half_hi <= 1'b0; blk <= 1'b0; dead <= 1'b0; tx_en <= 1'b0;
      wb <= '0; wcnt <= '0; wsr <= '0; tx <= '0; rbuf <= '0;
      seq_left <= '0; seq_we <= 1'b0; seq_hi <= 1'b0; seq_addr <= '0;
      seq_wd <= '0; seq_be <= '0; rd_pend <= 1'b0; rd_hi <= 1'b0;
      win_err <= 1'b0;
    end else begin
      rd_pend <= mem_req & ~seq_we;
      rd_hi   <= seq_hi;
      if (rd_pend) begin
        if (rd_hi) rbuf[63:32] <= mem_rdata;
        else       rbuf[31:0]  <= mem_rdata;
      end
      if (seq_left != 2'd0) begin
        seq_left <= seq_left - 2'd1;
        seq_addr <= seq_addr + 32'd4;
        seq_wd   <= {32'h0, seq_wd[63:32]};
        seq_be   <= 4'hF;
        seq_hi   <= 1'b1;
      end

      if (!sel) begin
        bcnt <= '0; bidx <= '0; wb <= '0; wcnt <= '0;
        dead <= 1'b0; tx_en <= 1'b0; blk <= 1'b0;
      end else if (rise) begin
        bcnt <= bcnt + 3'd1;
        rx   <= byte_in[6:0];
        if (tx_en) tx <= {tx[62:0], 1'b0};
        if (bcnt == 3'd7 && !dead) begin
          if (bidx != 4'd9) bidx <= bidx + 4'd1;
          if (bidx == 4'd0) begin
            cmd <= byte_in[2:0];
            if (byte_in > 8'd5) dead <= 1'b1;
          end else if (bidx < 4'd4) begin
            addr <= full_addr[23:0];
          end else if (bidx == 4'd4) begin
            half_hi <= aln_addr[1];
            nxt     <= is_rd ? aln_addr + 32'd8 : aln_addr;
            blk     <= half & ~in_win;
            if (half && !in_win) win_err <= 1'b1;
            if (is_rd) begin
              if (half && !in_win) rbuf <= '0;
              else begin
                seq_left <= burst ? 2'd2 : 2'd1;
                seq_we   <= 1'b0;
                seq_addr <= {aln_addr[31:2], 2'b00};
                seq_be   <= 4'hF;
                seq_hi   <= 1'b0;
              end
            end
          end else if (!is_rd) begin
            wsr <= wfull[55:0];
            if (wb == wlast) begin
              wb   <= '0;
              nxt  <= nxt + wstep;
              wcnt <= wcnt + 1'b1;
              if (!blk) begin
                seq_left <= burst ? 2'd2 : 2'd1;
                seq_we   <= 1'b1;
                seq_addr <= {nxt[31:2], 2'b00};
                seq_wd   <= wr_wd;
                seq_be   <= wr_be;
                seq_hi   <= 1'b0;
              end
              if (!burst || (int'(wcnt) + 1 >= MAXW)) dead <= 1'b1;
            end else wb <= wb + 3'd1;
          end else if (bidx == 4'd8) begin
            tx    <= tx_load;
            tx_en <= 1'b1;
            wcnt  <= 1;
            if (burst && MAXW > 1) begin
              seq_left <= 2'd2;
              seq_we   <= 1'b0;
              seq_addr <= nxt;
              seq_be   <= 4'hF;
              seq_hi   <= 1'b0;
              nxt      <= nxt + 32'd8;
            end
          end else if (bidx == 4'd9) begin
            if (wb == wlast) begin
              wb <= '0;
              if (burst && int'(wcnt) < MAXW) begin
                tx   <= tx_load;
                wcnt <= wcnt + 1'b1;
                if (int'(wcnt) + 1 < MAXW) begin
                  seq_left <= 2'd2;
                  seq_we   <= 1'b0;
                  seq_addr <= nxt;
                  seq_be   <= 4'hF;
                  seq_hi   <= 1'b0;
                  nxt      <= nxt + 32'd8;
                end
              end else begin
                tx_en <= 1'b0;
                dead  <= 1'b1;
              end
            end else wb <= wb + 3'd1;
          end
        end
      end
    end
  end

  a_r1_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> !miso);
  a_r4_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bidx <= 4'd8) |-> !miso);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso);
  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r10_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_be == 4'hF));
  a_r5_half_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_be != 4'hF) |->
      (mem_addr >= {WIN_LO[31:2], 2'b00} && mem_addr <= WIN_HI));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |=> win_err);
  a_r7_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wcnt) <= MAXW);
endmodule

// File: tb/spi_mem_bridge_test.sv
`timescale 1ns/1ps
module spi_mem_bridge_test;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, mem_req, mem_we, win_err;
  logic [31:0] mem_addr, mem_wdata, rdata;
  logic [3:0] mem_be;
  logic [31:0] mem [0:255];
  logic pre_en = 1'b0;
  logic [7:0] pre_idx = '0;
  logic [31:0] pre_val = '0;
  logic [7:0] txb [0:63];
  logic [7:0] rxb [0:63];
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  spi_mem_bridge #(.MAX_BURST(32)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(rdata), .win_err(win_err));

  always @(posedge clk) begin
    if (pre_en) mem[pre_idx] <= pre_val;
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else rdata <= mem[mem_addr[9:2]];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic preset(input logic [7:0] idx, input logic [31:0] val);
    @(posedge clk); #1;
    pre_idx = idx; pre_val = val; pre_en = 1'b1;
    @(posedge clk); #1;
    pre_en = 1'b0;
  endtask

  task automatic xb(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i]; #12;
      sclk = 1'b1; r[i] = miso; #12;
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input logic [7:0] c, input logic [31:0] a, input int n);
    logic [7:0] d;
    @(posedge clk); #1;
    cs_n = 1'b0; #24;
    xb(c, d);
    for (int k = 0; k < 4; k++) xb(a[31-8*k -: 8], d);
    for (int i = 0; i < n; i++) begin
      xb(txb[i], d);
      rxb[i] = d;
    end
    #24; cs_n = 1'b1; #60;
  endtask

  function automatic logic [31:0] rx32(input int i);
    return {rxb[i], rxb[i+1], rxb[i+2], rxb[i+3]};
  endfunction

  function automatic logic [31:0] tx32(input int i);
    return {txb[i], txb[i+1], txb[i+2], txb[i+3]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [63:0] g;
    logic [7:0] ib;
    logic [31:0] a;
    repeat (4) @(posedge clk);
    #1;
    chk("R11 reset miso", {63'h0, miso}, 64'h0);
    chk("R11 reset mem_req", {63'h0, mem_req}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 idle miso", {63'h0, miso}, 64'h0);
    chk("R6 win_err clear after reset", {63'h0, win_err}, 64'h0);

    for (int i = 0; i < 8; i++) begin
      preset(8'(16 + i), 32'h0);
      for (int k = 0; k < 4; k++) txb[k] = 8'(i * 16 + k + 1);
      a = 32'h2000_0040 + 32'(i * 4) + 32'(i % 4);
      txn(8'h03, a, 4);
      chk("R3 R2 word write", {32'h0, mem[16 + i]}, {32'h0, tx32(0)});
    end

    for (int i = 0; i < 8; i++) begin
      preset(8'(16 + i), {8'(i), 8'hC3, 8'(i * 3), 8'h96});
      for (int k = 0; k < 12; k++) txb[k] = 8'hFF;
      a = 32'h2000_0040 + 32'(i * 4) + 32'(3 - i % 4);
      txn(8'h02, a, 12);
      chk("R4 read dummy bytes", {32'h0, rx32(0)}, 64'h0);
      chk("R3 word read", {32'h0, rx32(4)}, {32'h0, mem[16 + i]});
      chk("R8 word read extra bytes", {32'h0, rx32(8)}, 64'h0);
    end

    for (int nw = 1; nw <= 5; nw++) begin
      ib = 8'(8'h20 + nw * 16);
      for (int j = 0; j < 10; j++) preset(8'(ib + j), 32'hDEAD_0000 + 32'(j));
      for (int k = 0; k < nw * 8; k++) txb[k] = 8'(nw * 37 + k);
      txn(8'h05, 32'h3000_0080 + 32'(nw * 64) + 32'(nw % 8), nw * 8);
      for (int w = 0; w < 5; w++) begin
        if (w < nw && w < 4) begin
          chk("R3 R7 burst write low", {32'h0, mem[ib + 2*w]}, {32'h0, tx32(8*w + 4)});
          chk("R3 R7 burst write high", {32'h0, mem[ib + 2*w + 1]}, {32'h0, tx32(8*w)});
        end else begin
          chk("R7 burst write beyond", {32'h0, mem[ib + 2*w]}, {32'h0, 32'hDEAD_0000 + 32'(2*w)});
          chk("R7 burst write beyond", {32'h0, mem[ib + 2*w + 1]}, {32'h0, 32'hDEAD_0000 + 32'(2*w + 1)});
        end
      end
    end

    for (int nw = 1; nw <= 5; nw++) begin
      ib = 8'(8'h40 + nw * 16);
      for (int j = 0; j < 10; j++) preset(8'(ib + j), {8'(ib + j), 8'hA5, 8'(j), 8'h3C});
      for (int k = 0; k < 4 + nw * 8; k++) txb[k] = 8'h00;
      txn(8'h04, 32'h4000_0100 + 32'(nw * 64), 4 + nw * 8);
      chk("R4 burst read dummy bytes", {32'h0, rx32(0)}, 64'h0);
      for (int w = 0; w < nw; w++) begin
        g = '0;
        for (int b = 0; b < 8; b++) g = {g[55:0], rxb[4 + 8*w + b]};
        if (w < 4) chk("R3 R7 burst read word", g, {mem[ib + 2*w + 1], mem[ib + 2*w]});
        else chk("R7 burst read beyond", g, 64'h0);
      end
    end

    txb[0] = 8'hAB; txb[1] = 8'hCD;
    preset(8'h00, 32'h1122_3344);
    txn(8'h01, 32'h1802_0000, 2);
    chk("R5 R10 half write low lanes", {32'h0, mem[0]}, {32'h0, 32'h1122_ABCD});
    preset(8'h00, 32'h1122_3344);
    txn(8'h01, 32'h1802_0003, 2);
    chk("R5 R10 R2 half write high lanes", {32'h0, mem[0]}, {32'h0, 32'hABCD_3344});
    preset(8'h00, 32'h1122_3344);
    txn(8'h01, 32'h1802_1000, 2);
    chk("R5 half write at window top", {32'h0, mem[0]}, {32'h0, 32'h1122_ABCD});
    chk("R6 no error inside window", {63'h0, win_err}, 64'h0);

    for (int k = 0; k < 8; k++) txb[k] = 8'h00;
    preset(8'h00, 32'h1122_3344);
    txn(8'h00, 32'h1802_0002, 8);
    chk("R3 half read high", {48'h0, rxb[4], rxb[5]}, 64'h1122);
    chk("R8 half read extra bytes", {48'h0, rxb[6], rxb[7]}, 64'h0);
    txn(8'h00, 32'h1802_0000, 6);
    chk("R3 half read low", {48'h0, rxb[4], rxb[5]}, 64'h3344);

    txb[0] = 8'hAB; txb[1] = 8'hCD;
    preset(8'h00, 32'h1122_3344);
    txn(8'h01, 32'h1802_1002, 2);
    chk("R5 half write above window", {32'h0, mem[0]}, {32'h0, 32'h1122_3344});
    chk("R6 error set", {63'h0, win_err}, 64'h1);
    preset(8'hFF, 32'h5566_7788);
    txn(8'h01, 32'h1801_FFFE, 2);
    chk("R5 half write below window", {32'h0, mem[255]}, {32'h0, 32'h5566_7788});
    for (int k = 0; k < 6; k++) txb[k] = 8'h00;
    txn(8'h00, 32'h1802_1002, 6);
    chk("R5 half read outside window", {48'h0, rxb[4], rxb[5]}, 64'h0);
    for (int k = 0; k < 4; k++) txb[k] = 8'(8'h71 + k);
    preset(8'h00, 32'h0);
    txn(8'h03, 32'h1802_2000, 4);
    chk("R5 word write ignores window", {32'h0, mem[0]}, {32'h0, tx32(0)});
    chk("R6 error stays set", {63'h0, win_err}, 64'h1);

    for (int c = 0; c < 4; c++) begin
      logic [7:0] cv;
      logic [7:0] acc;
      cv = (c == 0) ? 8'h06 : (c == 1) ? 8'h07 : (c == 2) ? 8'h80 : 8'hFF;
      preset(8'h80, 32'hCAFE_F00D);
      preset(8'h81, 32'h0BAD_BEEF);
      for (int k = 0; k < 8; k++) txb[k] = 8'h5A;
      txn(cv, 32'h0000_0200, 8);
      acc = '0;
      for (int k = 0; k < 8; k++) acc = acc | rxb[k];
      chk("R1 unknown command miso", {56'h0, acc}, 64'h0);
      chk("R1 unknown command memory", {mem[8'h81], mem[8'h80]}, {32'h0BAD_BEEF, 32'hCAFE_F00D});
    end

    preset(8'hC0, 32'h1234_5678);
    for (int k = 0; k < 13; k++) txb[k] = 8'(8'h90 + k);
    txn(8'h03, 32'h0000_0300, 3);
    chk("R9 partial word write dropped", {32'h0, mem[8'hC0]}, {32'h0, 32'h1234_5678});
    for (int j = 0; j < 4; j++) preset(8'(8'hD0 + j), 32'hEEEE_0000 + 32'(j));
    txn(8'h05, 32'h0000_0340, 13);
    chk("R9 burst full word kept", {mem[8'hD1], mem[8'hD0]}, {tx32(0), tx32(4)});
    chk("R9 burst partial word dropped", {mem[8'hD3], mem[8'hD2]}, {32'hEEEE_0003, 32'hEEEE_0002});

    preset(8'hE0, 32'h0);
    preset(8'hE1, 32'h7777_7777);
    for (int k = 0; k < 8; k++) txb[k] = 8'(8'hB0 + k);
    txn(8'h03, 32'h0000_0380, 8);
    chk("R8 word write first word", {32'h0, mem[8'hE0]}, {32'h0, tx32(0)});
    chk("R8 word write extra ignored", {32'h0, mem[8'hE1]}, {32'h0, 32'h7777_7777});

    repeat (4) @(posedge clk);
    #1;
    chk("R11 miso low after release", {63'h0, miso}, 64'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule